// File: doc/BRIEF.md
# Two-Stage Prioritized Event Controller

This block gathers a set of asynchronous peripheral interrupt lines and a handful of core event sources, and hands the processor one event at a time. Its first stage resynchronises the peripheral lines. It then steers each enabled line onto one of the general-purpose core levels (7 to 15), using a per-source level assignment and enable bit.

Its second stage keeps one pending latch per level across sixteen fixed levels, where a lower index means a higher priority. It applies a per-level enable mask that cannot silence levels 0 to 2. It keeps a record of the levels in service, so that only a strictly more urgent event can nest. It presents the winning level index with a valid strobe. When the processor acknowledges, the controller moves that level from pending to in-service and captures the return address. A return-from-event command ends service of a level.

Software can raise levels 14 and 15 directly. Exceptions are accepted as synchronous pulses, and their faulting address is held aside for the return register.

Top module: `evt_ctrl_top`

## Requirements
- R1: After reset no event is presented, every pending and in-service bit is 0, the core enable mask is 0, and every peripheral source is disabled, so a peripheral edge pends nothing.
- R2: Among pending, enabled levels that are not in service, the lowest index is presented on `evt_idx` with `evt_valid` high. Level 0 is the most urgent.
- R3: A rising edge on an enabled peripheral source pends the level held in its 4-bit assignment field when that value is 7 to 15. It appears on `pend_o` within four clocks. Assignment values 0 to 6 route nowhere.
- R4: A peripheral source whose enable bit `asg_en` was written as 0 pends no level on an edge.
- R5: Core mask bit i = 1 enables presentation of level i. Bits 0 to 2 are ignored, so levels 0 to 2 are always enabled. A masked level still latches as pending.
- R6: An event is presented only when its index is below every in-service level. An in-service level is never presented.
- R7: `evt_ack` while `evt_valid` is high clears the pending bit of `evt_idx` and sets its in-service bit on the same edge. On that edge it also captures `pc_in` into that level's return register, which is read through `ret_sel`/`ret_addr`.
- R8: A `rtn_we` pulse clears the in-service bit of level `rtn_lvl`, which lets lower-priority pending events through.
- R9: A `swi_we` write pends level 14 when `swi_set[0]` is 1 and level 15 when `swi_set[1]` is 1, exactly like a hardware request.
- R10: While `exc_req` is high at a clock edge, level 3 becomes pending and `exc_pc` is latched. Acknowledging level 3 stores that latched address, not `pc_in`, as its return address.
- R11: Level 4 is reserved and never becomes pending.
- R12: Requests on levels 0 to 2, 5 to 15 are edge-triggered: a line held high pends its level once only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_irq | input | N_SRC | Asynchronous peripheral request lines |
| emu_req | input | 1 | Emulation request (level 0) |
| rst_req | input | 1 | Reset event request (level 1) |
| nmi_req | input | 1 | Non-maskable request (level 2) |
| hwerr_req | input | 1 | Hardware error request (level 5) |
| tmr_req | input | 1 | Core timer request (level 6) |
| exc_req | input | 1 | Synchronous exception pulse (level 3) |
| exc_pc | input | ADDR_W | Faulting instruction address |
| asg_we | input | 1 | Write a source's assignment and enable |
| asg_src | input | SRC_W | Source index written |
| asg_lvl | input | 4 | Target core level for that source |
| asg_en | input | 1 | Source enable bit |
| imask_we | input | 1 | Write core enable mask |
| imask_wdata | input | 16 | New core enable mask |
| swi_we | input | 1 | Software raise strobe |
| swi_set | input | 2 | Raise level 14 (bit 0) / level 15 (bit 1) |
| evt_valid | output | 1 | An event is presented |
| evt_idx | output | 4 | Presented level |
| evt_ack | input | 1 | Processor takes the presented event |
| pc_in | input | ADDR_W | Return address for non-exception events |
| rtn_we | input | 1 | Return from event |
| rtn_lvl | input | 4 | Level being returned from |
| ret_sel | input | 4 | Return register selector |
| ret_addr | output | ADDR_W | Selected return register |
| pend_o | output | 16 | Pending bits |
| active_o | output | 16 | In-service bits |

## Verification
The bench nests a timer event on top of a peripheral level and checks the order of service. A controller that compared against the wrong end of the in-service set would either starve the timer or let a lower level through. It raises the non-maskable and both software levels together with the mask cleared. A design that masked level 2 would present nothing, and one that ignored the mask would present level 14 too early. It changes `exc_pc` after the exception pulse, which catches a design that stores the live address or `pc_in` for level 3. It holds peripheral lines high after service to expose level-triggered pending, and it writes a non-general assignment value, which a design missing the range check would route into a low level.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int NLVL     = 16;
  localparam int LVL_W    = 4;
  localparam int GP_LO    = 7;
  localparam int GP_CNT   = NLVL - GP_LO;
  localparam int LVL_EMU  = 0;
  localparam int LVL_RST  = 1;
  localparam int LVL_NMI  = 2;
  localparam int LVL_EXC  = 3;
  localparam int LVL_RSVD = 4;
  localparam int LVL_HWE  = 5;
  localparam int LVL_TMR  = 6;
  localparam int LVL_SW0  = 14;
  localparam int LVL_SW1  = 15;
  localparam logic [NLVL-1:0] ALWAYS_ON = 16'h0007;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/evc_route.sv
module evc_route
  import evc_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic             asg_we,
  input  logic [SRC_W-1:0] asg_src,
  input  lvl_t             asg_lvl,
  input  logic             asg_en,
  output logic [NLVL-1:0]  gp_req
);
  lvl_t             asg_q [N_SRC];
  lvl_t             asg_d [N_SRC];
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] en_d;

  always_comb begin
    for (int s = 0; s < N_SRC; s++) begin
      asg_d[s] = asg_q[s];
    end
    en_d = en_q;
    if (asg_we) begin
      asg_d[asg_src] = asg_lvl;
      en_d[asg_src]  = asg_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SRC; s++) begin
        asg_q[s] <= lvl_t'(GP_LO + (s % (GP_CNT - 2)));
      end
      en_q <= '0;
    end else begin
      for (int s = 0; s < N_SRC; s++) begin
        asg_q[s] <= asg_d[s];
      end
      en_q <= en_d;
    end
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    if (l >= GP_LO) begin : g_gp
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int s = 0; s < N_SRC; s++) begin
          if (en_q[s] && src_in[s] && (asg_q[s] == lvl_t'(l))) hit = 1'b1;
        end
      end
      assign gp_req[l] = hit;
    end else begin : g_none
      assign gp_req[l] = 1'b0;
    end
  end
endmodule

// File: rtl/evc_arb.sv
module evc_arb
  import evc_pkg::*;
(
  input  logic [NLVL-1:0] pend,
  input  logic [NLVL-1:0] enable,
  input  logic [NLVL-1:0] active,
  output logic            valid,
  output lvl_t            idx
);
  logic [NLVL-1:0] elig;
  logic            found;
  lvl_t            win;
  logic [LVL_W:0]  top_act;

  assign elig = pend & enable & ~active;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (elig[l]) begin
        found = 1'b1;
        win   = lvl_t'(l);
      end
    end
  end

  always_comb begin
    top_act = (LVL_W + 1)'(NLVL);
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (active[l]) top_act = (LVL_W + 1)'(l);
    end
  end

  assign valid = found && ({1'b0, win} < top_act);
  assign idx   = win;
endmodule

// File: rtl/evc_core.sv
module evc_core
  import evc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLVL-1:0]   hw_req,
  input  logic              exc_req,
  input  logic [ADDR_W-1:0] exc_pc,
  input  logic              imask_we,
  input  logic [NLVL-1:0]   imask_wdata,
  input  logic              swi_we,
  input  logic [1:0]        swi_set,
  input  logic              evt_ack,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              rtn_we,
  input  lvl_t              rtn_lvl,
  input  lvl_t              ret_sel,
  output logic              evt_valid,
  output lvl_t              evt_idx,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [NLVL-1:0]   pend_o,
  output logic [NLVL-1:0]   active_o
);
  logic [NLVL-1:0]   req_q;
  logic [NLVL-1:0]   pend_q, pend_d;
  logic [NLVL-1:0]   act_q, act_d;
  logic [NLVL-1:0]   imask_q, imask_d;
  logic [ADDR_W-1:0] xpc_q, xpc_d;
  logic [ADDR_W-1:0] ret_q [NLVL];
  logic [NLVL-1:0]   rise;
  logic [NLVL-1:0]   raise;
  logic [ADDR_W-1:0] cap;
  logic              take;
  logic              arb_valid;
  lvl_t              arb_idx;

  evc_arb u_arb (
    .pend   (pend_q),
    .enable (imask_q | ALWAYS_ON),
    .active (act_q),
    .valid  (arb_valid),
    .idx    (arb_idx)
  );

  assign take = arb_valid && evt_ack;
  assign rise = hw_req & ~req_q;

  always_comb begin
    raise = rise;
    if (swi_we) begin
      raise[LVL_SW0] = raise[LVL_SW0] | swi_set[0];
      raise[LVL_SW1] = raise[LVL_SW1] | swi_set[1];
    end
    raise[LVL_EXC]  = exc_req;
    raise[LVL_RSVD] = 1'b0;
  end

  always_comb begin
    pend_d = pend_q;
    if (take) pend_d[arb_idx] = 1'b0;
    pend_d = pend_d | raise;
  end

  always_comb begin
    act_d = act_q;
    if (rtn_we) act_d[rtn_lvl] = 1'b0;
    if (take) act_d[arb_idx] = 1'b1;
  end

  always_comb begin
    imask_d = imask_q;
    if (imask_we) imask_d = imask_wdata;
  end

  always_comb begin
    xpc_d = xpc_q;
    if (exc_req) xpc_d = exc_pc;
  end

  assign cap = (arb_idx == lvl_t'(LVL_EXC)) ? xpc_q : pc_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      pend_q  <= '0;
      act_q   <= '0;
      imask_q <= '0;
      xpc_q   <= '0;
    end else begin
      req_q   <= hw_req;
      pend_q  <= pend_d;
      act_q   <= act_d;
      imask_q <= imask_d;
      xpc_q   <= xpc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NLVL; l++) begin
        ret_q[l] <= '0;
      end
    end else if (take) begin
      ret_q[arb_idx] <= cap;
    end
  end

  assign evt_valid = arb_valid;
  assign evt_idx   = arb_idx;
  assign ret_addr  = ret_q[ret_sel];
  assign pend_o    = pend_q;
  assign active_o  = act_q;
endmodule

// File: rtl/evt_ctrl_top.sv
module evt_ctrl_top
  import evc_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 32,
  parameter int SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  periph_irq,
  input  logic              emu_req,
  input  logic              rst_req,
  input  logic              nmi_req,
  input  logic              hwerr_req,
  input  logic              tmr_req,
  input  logic              exc_req,
  input  logic [ADDR_W-1:0] exc_pc,
  input  logic              asg_we,
  input  logic [SRC_W-1:0]  asg_src,
  input  logic [3:0]        asg_lvl,
  input  logic              asg_en,
  input  logic              imask_we,
  input  logic [15:0]       imask_wdata,
  input  logic              swi_we,
  input  logic [1:0]        swi_set,
  output logic              evt_valid,
  output logic [3:0]        evt_idx,
  input  logic              evt_ack,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              rtn_we,
  input  logic [3:0]        rtn_lvl,
  input  logic [3:0]        ret_sel,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [15:0]       pend_o,
  output logic [15:0]       active_o
);
  logic [N_SRC-1:0] irq_s;
  logic [NLVL-1:0]  gp_req;
  logic [NLVL-1:0]  fixed_req;
  logic [NLVL-1:0]  hw_req;

  evc_sync #(.W(N_SRC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (periph_irq),
    .d_sync  (irq_s)
  );

  evc_route #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_in  (irq_s),
    .asg_we  (asg_we),
    .asg_src (asg_src),
    .asg_lvl (asg_lvl),
    .asg_en  (asg_en),
    .gp_req  (gp_req)
  );

  always_comb begin
    fixed_req          = '0;
    fixed_req[LVL_EMU] = emu_req;
    fixed_req[LVL_RST] = rst_req;
    fixed_req[LVL_NMI] = nmi_req;
    fixed_req[LVL_HWE] = hwerr_req;
    fixed_req[LVL_TMR] = tmr_req;
  end

  assign hw_req = fixed_req | gp_req;

  evc_core #(.ADDR_W(ADDR_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_req      (hw_req),
    .exc_req     (exc_req),
    .exc_pc      (exc_pc),
    .imask_we    (imask_we),
    .imask_wdata (imask_wdata),
    .swi_we      (swi_we),
    .swi_set     (swi_set),
    .evt_ack     (evt_ack),
    .pc_in       (pc_in),
    .rtn_we      (rtn_we),
    .rtn_lvl     (rtn_lvl),
    .ret_sel     (ret_sel),
    .evt_valid   (evt_valid),
    .evt_idx     (evt_idx),
    .ret_addr    (ret_addr),
    .pend_o      (pend_o),
    .active_o    (active_o)
  );
endmodule

// File: rtl/evc_chk.sv
module evc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_valid,
  input logic [3:0]  evt_idx,
  input logic        evt_ack,
  input logic        rtn_we,
  input logic [3:0]  rtn_lvl,
  input logic        swi_we,
  input logic [1:0]  swi_set,
  input logic [15:0] pend_o,
  input logic [15:0] active_o
);
  AST_VALID_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (pend_o[evt_idx] && !active_o[evt_idx])); // R6

  AST_ACK_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ack) |=> active_o[$past(evt_idx)]); // R7

  AST_RTN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rtn_we && !(evt_valid && evt_ack && evt_idx == rtn_lvl)) |=> !active_o[$past(rtn_lvl)]); // R8

  AST_SWI_LOW_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_we && swi_set[0]) |=> pend_o[14]); // R9

  AST_SWI_HIGH_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_we && swi_set[1]) |=> pend_o[15]); // R9

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o[4]); // R11

  AST_NMI_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o[2] && pend_o[1:0] == 2'b00 && active_o[2:0] == 3'b000) |-> (evt_valid && evt_idx == 4'd2)); // R5
endmodule

bind evt_ctrl_top evc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .evt_idx   (evt_idx),
  .evt_ack   (evt_ack),
  .rtn_we    (rtn_we),
  .rtn_lvl   (rtn_lvl),
  .swi_we    (swi_we),
  .swi_set   (swi_set),
  .pend_o    (pend_o),
  .active_o  (active_o)
);

// File: tb/sim_evt_ctrl_top.sv
`timescale 1ns/1ps
module sim_evt_ctrl_top;
  localparam int N_SRC  = 8;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N_SRC-1:0]  periph_irq;
  logic              emu_req, rst_req, nmi_req, hwerr_req, tmr_req, exc_req;
  logic [ADDR_W-1:0] exc_pc;
  logic              asg_we;
  logic [2:0]        asg_src;
  logic [3:0]        asg_lvl;
  logic              asg_en;
  logic              imask_we;
  logic [15:0]       imask_wdata;
  logic              swi_we;
  logic [1:0]        swi_set;
  logic              evt_valid;
  logic [3:0]        evt_idx;
  logic              evt_ack;
  logic [ADDR_W-1:0] pc_in;
  logic              rtn_we;
  logic [3:0]        rtn_lvl;
  logic [3:0]        ret_sel;
  logic [ADDR_W-1:0] ret_addr;
  logic [15:0]       pend_o;
  logic [15:0]       active_o;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  evt_ctrl_top #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic route(input int src, input int lvl, input bit en);
    @(negedge clk);
    asg_we = 1'b1; asg_src = 3'(src); asg_lvl = 4'(lvl); asg_en = en;
    @(negedge clk);
    asg_we = 1'b0;
  endtask

  task automatic set_mask(input logic [15:0] m);
    @(negedge clk);
    imask_we = 1'b1; imask_wdata = m;
    @(negedge clk);
    imask_we = 1'b0;
  endtask

  // driver: pushes the expected level, then acknowledges
  task automatic serve(input int lvl, input logic [ADDR_W-1:0] pc);
    exp_q.push_back(lvl);
    @(negedge clk);
    evt_ack = 1'b1; pc_in = pc;
    @(negedge clk);
    evt_ack = 1'b0;
  endtask

  task automatic ret_from(input int lvl);
    @(negedge clk);
    rtn_we = 1'b1; rtn_lvl = 4'(lvl);
    @(negedge clk);
    rtn_we = 1'b0;
  endtask

  // monitor: compares every taken event against the scoreboard
  always begin
    @(negedge clk);
    #1;
    if (rst_n && evt_ack) begin
      if (!evt_valid) begin
        chk(1'b0, "R7 ack without event", 64'(evt_valid), 64'd1);
      end else if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected event", 64'(evt_idx), 64'hff);
      end else begin
        automatic int e = exp_q.pop_front();
        chk(evt_idx == 4'(e), "R2 R6 served level", 64'(evt_idx), 64'(e));
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    periph_irq = '0;
    {emu_req, rst_req, nmi_req, hwerr_req, tmr_req, exc_req} = '0;
    exc_pc = '0; asg_we = 1'b0; asg_src = '0; asg_lvl = '0; asg_en = 1'b0;
    imask_we = 1'b0; imask_wdata = '0; swi_we = 1'b0; swi_set = '0;
    evt_ack = 1'b0; pc_in = '0; rtn_we = 1'b0; rtn_lvl = '0; ret_sel = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(!evt_valid, "R1 valid after reset", 64'(evt_valid), 64'd0);
    chk(pend_o == 16'h0 && active_o == 16'h0, "R1 pend/active after reset", {32'(pend_o), 32'(active_o)}, 64'd0);

    // R1: sources disabled at reset
    periph_irq[0] = 1'b1;
    tick(5);
    chk(pend_o == 16'h0, "R1 disabled source pends nothing", 64'(pend_o), 64'd0);
    periph_irq[0] = 1'b0;
    tick(3);

    // R3 / R5: route source 0 to level 9, mask still clear
    route(0, 9, 1'b1);
    periph_irq[0] = 1'b1;
    tick(4);
    chk(pend_o == 16'h0200, "R3 source 0 pends level 9", 64'(pend_o), 64'h0200);
    chk(!evt_valid, "R5 masked level not presented", 64'(evt_valid), 64'd0);
    set_mask(16'hFFF8);
    tick(1);
    chk(evt_valid && evt_idx == 4'd9, "R5 enabled level presented", 64'(evt_idx), 64'd9);
    serve(9, 32'h0000_0100);
    tick(1);
    chk(active_o == 16'h0200 && pend_o == 16'h0, "R7 ack moves pending to active", {32'(active_o), 32'(pend_o)}, {32'h0200, 32'h0});
    ret_sel = 4'd9;
    tick(1);
    chk(ret_addr == 32'h100, "R7 return address captured", 64'(ret_addr), 64'h100);

    // R12: held line does not re-pend
    tick(6);
    chk(pend_o[9] == 1'b0, "R12 held line pends once", 64'(pend_o), 64'h0);

    // R6 nesting
    route(1, 12, 1'b1);
    periph_irq[1] = 1'b1;
    tick(4);
    chk(pend_o[12] && !evt_valid, "R6 lower level blocked by active 9", {32'(pend_o), 32'(evt_valid)}, {32'h1000, 32'h0});
    tmr_req = 1'b1;
    tick(1);
    chk(evt_valid && evt_idx == 4'd6, "R6 timer preempts", 64'(evt_idx), 64'd6);
    serve(6, 32'h0000_0200);
    ret_sel = 4'd6;
    tick(1);
    chk(ret_addr == 32'h200, "R7 timer return address", 64'(ret_addr), 64'h200);
    chk(active_o == 16'h0240, "R6 nested active set", 64'(active_o), 64'h0240);
    ret_from(6);
    tick(1);
    chk(active_o == 16'h0200 && !evt_valid, "R8 return clears level 6 only", {32'(active_o), 32'(evt_valid)}, {32'h0200, 32'h0});
    ret_from(9);
    tick(1);
    chk(evt_valid && evt_idx == 4'd12, "R8 return releases level 12", 64'(evt_idx), 64'd12);
    serve(12, 32'h0000_0300);
    ret_from(12);
    periph_irq = '0;
    tmr_req = 1'b0;
    tick(4);

    // R4: disabled source
    route(2, 8, 1'b0);
    periph_irq[2] = 1'b1;
    tick(5);
    chk(pend_o == 16'h0, "R4 disabled source ignored", 64'(pend_o), 64'h0);

    // R3: assignment below 7 routes nowhere
    route(3, 5, 1'b1);
    periph_irq[3] = 1'b1;
    tick(5);
    chk(pend_o == 16'h0 && !evt_valid, "R3 assignment 5 drops", 64'(pend_o), 64'h0);
    periph_irq = '0;
    tick(3);

    // R9 / R5 / R2: software levels with NMI, mask cleared
    set_mask(16'h0000);
    @(negedge clk);
    swi_we = 1'b1; swi_set = 2'b11; nmi_req = 1'b1;
    @(negedge clk);
    swi_we = 1'b0; swi_set = 2'b00;
    chk(pend_o == 16'hC004, "R9 software and NMI pending", 64'(pend_o), 64'hC004);
    chk(evt_valid && evt_idx == 4'd2, "R5 NMI ignores mask", 64'(evt_idx), 64'd2);
    serve(2, 32'h0000_0400);
    ret_from(2);
    tick(1);
    chk(!evt_valid && pend_o == 16'hC000, "R5 masked software levels held", 64'(pend_o), 64'hC000);
    set_mask(16'hFFFF);
    tick(1);
    chk(evt_valid && evt_idx == 4'd14, "R2 level 14 before 15", 64'(evt_idx), 64'd14);
    serve(14, 32'h0000_0500);
    ret_from(14);
    serve(15, 32'h0000_0600);
    ret_from(15);
    nmi_req = 1'b0;

    // R10: exception address latched
    @(negedge clk);
    exc_req = 1'b1; exc_pc = 32'h000B_EEF0;
    @(negedge clk);
    exc_req = 1'b0; exc_pc = 32'h0000_0111;
    chk(evt_valid && evt_idx == 4'd3, "R10 exception pends level 3", 64'(evt_idx), 64'd3);
    serve(3, 32'h0000_0300);
    ret_sel = 4'd3;
    tick(1);
    chk(ret_addr == 32'h000B_EEF0, "R10 exception return address", 64'(ret_addr), 64'hBEEF0);
    ret_from(3);
    tick(1);
    chk(pend_o[4] == 1'b0 && !evt_valid, "R11 reserved level idle", 64'(pend_o), 64'h0);

    // R2 / R3: two peripherals on different general levels
    route(4, 8, 1'b1);
    route(5, 11, 1'b1);
    @(negedge clk);
    periph_irq[4] = 1'b1; periph_irq[5] = 1'b1;
    tick(4);
    chk(pend_o == 16'h0900, "R3 two sources pend", 64'(pend_o), 64'h0900);
    chk(evt_valid && evt_idx == 4'd8, "R2 level 8 wins over 11", 64'(evt_idx), 64'd8);
    serve(8, 32'h0000_0700);
    ret_from(8);
    serve(11, 32'h0000_0800);
    ret_from(11);
    tick(2);
    chk(exp_q.size() == 0 && active_o == 16'h0 && pend_o == 16'h0, "R8 all served and returned",
        {32'(exp_q.size()), 16'(active_o), 16'(pend_o)}, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule